// File: doc/BRIEF.md
# Vectored Interrupt Controller

A register-mapped interrupt controller for up to 32 sources, reached over an APB-style bus in which an access is the cycle where `psel` and `penable` are both high. Each source is pending when its input line is high or when software has set its soft-pending bit. An enable mask filters the pending set. A select mask steers each surviving source to either the normal request output or the fast request output.

Sixteen vector slots, numbered 0 (highest priority) to 15, each hold a handler address and a control word that names one source. Reading the current-vector register returns the address of the best matching slot and marks that slot as in service. Writing that register retires the highest-priority slot still in service, so nested handlers unwind in order. A protection bit can restrict register writes to privileged accesses.

Top module: `vec_intc`

## Requirements
- R1: The raw status word (offset 0x08) reads the bitwise OR of the source lines and the soft-pending bits.
- R2: A write to 0x10 sets every enable bit that is 1 in the data, and a write to 0x14 clears every enable bit that is 1 in the data. A 0 leaves the bit as it is. A read of 0x10 returns the enable mask.
- R3: Writes to 0x18 (set) and 0x1C (clear) change the soft-pending bits with the same rule as R2, and a read of 0x18 returns them. A set soft bit makes its source pending while the source line is low.
- R4: The select mask is at 0x0C, and bit value 1 routes that source to the fast path. The normal status at 0x00 equals raw AND enable AND NOT select. The fast status at 0x04 equals raw AND enable AND select. `irqReq` and `fiqReq` are the OR of all bits of each status.
- R5: Slot n has its handler address at 0x100+4n and its control word at 0x200+4n. Control bit 5 enables the slot and bits 4:0 name its source. Both registers read back what was written, the control word as 6 bits.
- R6: A read of 0x30 returns the address of the lowest-numbered enabled, unblocked slot whose source bit is set in the normal status. When no slot qualifies, it returns the default address held at 0x34.
- R7: A read of 0x30 that finds a slot puts that slot in service. A slot is blocked while it, or any lower-numbered slot, is in service. A write of any value to 0x30 takes the lowest-numbered in-service slot out of service, and has no effect when none is in service.
- R8: Bit 0 of 0x20 is the protection bit. While it is 1, writes made with `privAcc` low are ignored.
- R9: Offsets 0xFE0, 0xFE4, 0xFE8 and 0xFEC return bytes 0 to 3 of the `ID_WORD` parameter in bits 7:0. Bits 19:12 of that word hold the vendor code.
- R10: After reset the enable, select, soft, protection, slot and in-service state is zero. Unmapped or unaligned offsets, including the test control word at 0x300, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset |
| pwdata | input | 32 | Write data |
| privAcc | input | 1 | Access is privileged |
| prdata | output | 32 | Read data, valid during the access phase |
| srcLines | input | NUM_SRC | Interrupt source lines, active high |
| irqReq | output | 1 | Normal interrupt request |
| fiqReq | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with its default parameters: 32 sources and 16 slots. With these values every offset in the map can be reached, and the bench can sweep each source line through the raw, normal and fast status words. Slot n is bound to source 7n mod 32. Because 7 is odd, this gives 16 distinct sources, so a sweep over which slots are active checks every priority position, and a source that no slot names checks the default address. A fixed sequence of vector reads and writes then covers nesting, blocking and unwinding.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;
  localparam int MAX_SLOTS = 16;
  localparam int SLOT_IW   = 4;
  localparam int WORD_AW   = 10;

  typedef struct packed {
    logic enSet;
    logic enClr;
    logic softSet;
    logic softClr;
    logic selWr;
    logic protWr;
    logic defWr;
    logic vecAddrWr;
    logic vecCtlWr;
    logic vecAck;
    logic vecTake;
    logic [SLOT_IW-1:0] slot;
    logic [WORD_AW-1:0] rdWord;
  } ctrl_strobe_t;
endpackage

// File: rtl/vec_intc_ctrl.sv
module vec_intc_ctrl
  import vec_intc_pkg::*;
(
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [11:0] paddr,
  input  logic        privAcc,
  input  logic        protectOn,
  output ctrl_strobe_t strb
);
  localparam logic [WORD_AW-1:0] W_SEL     = 10'h003;
  localparam logic [WORD_AW-1:0] W_EN_SET  = 10'h004;
  localparam logic [WORD_AW-1:0] W_EN_CLR  = 10'h005;
  localparam logic [WORD_AW-1:0] W_SW_SET  = 10'h006;
  localparam logic [WORD_AW-1:0] W_SW_CLR  = 10'h007;
  localparam logic [WORD_AW-1:0] W_PROT    = 10'h008;
  localparam logic [WORD_AW-1:0] W_CURVEC  = 10'h00C;
  localparam logic [WORD_AW-1:0] W_DEFVEC  = 10'h00D;
  localparam logic [5:0]         W_ADDRBLK = 6'h04;
  localparam logic [5:0]         W_CTLBLK  = 6'h08;

  logic aligned;
  logic wrOk;
  logic rdOk;
  logic [WORD_AW-1:0] word;

  assign aligned = (paddr[1:0] == 2'b00);
  assign word    = paddr[11:2];
  assign wrOk    = psel && penable && pwrite && aligned && (!protectOn || privAcc);
  assign rdOk    = psel && penable && !pwrite && aligned;

  always_comb begin
    strb        = '0;
    strb.slot   = paddr[5:2];
    strb.rdWord = aligned ? word : '1;
    if (wrOk) begin
      case (word)
        W_SEL:    strb.selWr   = 1'b1;
        W_EN_SET: strb.enSet   = 1'b1;
        W_EN_CLR: strb.enClr   = 1'b1;
        W_SW_SET: strb.softSet = 1'b1;
        W_SW_CLR: strb.softClr = 1'b1;
        W_PROT:   strb.protWr  = 1'b1;
        W_CURVEC: strb.vecAck  = 1'b1;
        W_DEFVEC: strb.defWr   = 1'b1;
        default: begin
          if (word[9:4] == W_ADDRBLK) strb.vecAddrWr = 1'b1;
          if (word[9:4] == W_CTLBLK)  strb.vecCtlWr  = 1'b1;
        end
      endcase
    end
    if (rdOk && word == W_CURVEC) strb.vecTake = 1'b1;
  end
endmodule

// File: rtl/vec_intc_dp.sv
module vec_intc_dp
  import vec_intc_pkg::*;
#(
  parameter int          NUM_SRC  = 32,
  parameter int          NUM_SLOT = 16,
  parameter int          VEC_W    = 32,
  parameter logic [31:0] ID_WORD  = 32'h0015_5A3C
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobe_t       strb,
  input  logic [31:0]        wdata,
  input  logic [NUM_SRC-1:0] srcLines,
  output logic [31:0]        rdata,
  output logic               irqReq,
  output logic               fiqReq,
  output logic               protectOn,
  output logic [NUM_SRC-1:0] enableReg,
  output logic [NUM_SRC-1:0] selectReg,
  output logic [NUM_SRC-1:0] softReg,
  output logic [NUM_SLOT-1:0] inService
);
  localparam int CTL_W = 6;
  localparam logic [WORD_AW-1:0] ID_BASE = 10'h3F8;

  logic [NUM_SRC-1:0]  rawStat, irqStat, fiqStat;
  logic [31:0]         irqStatWide;
  logic [VEC_W-1:0]    defVec;
  logic [VEC_W-1:0]    vecAddr [NUM_SLOT];
  logic [CTL_W-1:0]    vecCtl  [NUM_SLOT];
  logic [NUM_SLOT-1:0] slotHit, slotBlocked;
  logic                found;
  logic [SLOT_IW-1:0]  winIdx;
  logic [VEC_W-1:0]    curVec;

  assign rawStat     = srcLines | softReg;
  assign irqStat     = rawStat & enableReg & ~selectReg;
  assign fiqStat     = rawStat & enableReg & selectReg;
  assign irqStatWide = 32'(irqStat);
  assign irqReq      = |irqStat;
  assign fiqReq      = |fiqStat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableReg <= '0;
      selectReg <= '0;
      softReg   <= '0;
      protectOn <= 1'b0;
      defVec    <= '0;
    end else begin
      if (strb.enSet)   enableReg <= enableReg | wdata[NUM_SRC-1:0];
      if (strb.enClr)   enableReg <= enableReg & ~wdata[NUM_SRC-1:0];
      if (strb.softSet) softReg   <= softReg | wdata[NUM_SRC-1:0];
      if (strb.softClr) softReg   <= softReg & ~wdata[NUM_SRC-1:0];
      if (strb.selWr)   selectReg <= wdata[NUM_SRC-1:0];
      if (strb.protWr)  protectOn <= wdata[0];
      if (strb.defWr)   defVec    <= wdata[VEC_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_SLOT; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vecAddr[g] <= '0;
        vecCtl[g]  <= '0;
      end else begin
        if (strb.vecAddrWr && strb.slot == SLOT_IW'(g)) vecAddr[g] <= wdata[VEC_W-1:0];
        if (strb.vecCtlWr  && strb.slot == SLOT_IW'(g)) vecCtl[g]  <= wdata[CTL_W-1:0];
      end
    end
    assign slotHit[g]     = vecCtl[g][5] && irqStatWide[vecCtl[g][4:0]];
    assign slotBlocked[g] = |inService[g:0];
  end

  always_comb begin
    found  = 1'b0;
    winIdx = '0;
    for (int i = NUM_SLOT - 1; i >= 0; i--) begin
      if (slotHit[i] && !slotBlocked[i]) begin
        found  = 1'b1;
        winIdx = SLOT_IW'(i);
      end
    end
  end

  assign curVec = found ? vecAddr[winIdx] : defVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inService <= '0;
    end else if (strb.vecTake && found) begin
      inService <= inService | (NUM_SLOT'(1) << winIdx);
    end else if (strb.vecAck) begin
      inService <= inService & (inService - NUM_SLOT'(1));
    end
  end

  always_comb begin
    rdata = '0;
    case (strb.rdWord)
      10'h000: rdata = 32'(irqStat);
      10'h001: rdata = 32'(fiqStat);
      10'h002: rdata = 32'(rawStat);
      10'h003: rdata = 32'(selectReg);
      10'h004: rdata = 32'(enableReg);
      10'h006: rdata = 32'(softReg);
      10'h008: rdata = 32'(protectOn);
      10'h00C: rdata = 32'(curVec);
      10'h00D: rdata = 32'(defVec);
      default: begin
        if (strb.rdWord[9:4] == 6'h04 && int'(strb.slot) < NUM_SLOT)
          rdata = 32'(vecAddr[strb.slot]);
        if (strb.rdWord[9:4] == 6'h08 && int'(strb.slot) < NUM_SLOT)
          rdata = 32'(vecCtl[strb.slot]);
        if (strb.rdWord[9:2] == ID_BASE[9:2])
          rdata = {24'd0, ID_WORD[8*strb.rdWord[1:0] +: 8]};
      end
    endcase
  end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vec_intc_pkg::*;
#(
  parameter int          NUM_SRC  = 32,
  parameter int          NUM_SLOT = 16,
  parameter int          VEC_W    = 32,
  parameter logic [31:0] ID_WORD  = 32'h0015_5A3C
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [11:0]        paddr,
  input  logic [31:0]        pwdata,
  input  logic               privAcc,
  output logic [31:0]        prdata,
  input  logic [NUM_SRC-1:0] srcLines,
  output logic               irqReq,
  output logic               fiqReq
);
  ctrl_strobe_t        strb;
  logic                protectOn;
  logic [NUM_SRC-1:0]  enableReg, selectReg, softReg;
  logic [NUM_SLOT-1:0] inService;

  vec_intc_ctrl u_ctrl (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .privAcc(privAcc), .protectOn(protectOn), .strb(strb)
  );

  vec_intc_dp #(
    .NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .VEC_W(VEC_W), .ID_WORD(ID_WORD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(pwdata), .srcLines(srcLines),
    .rdata(prdata), .irqReq(irqReq), .fiqReq(fiqReq), .protectOn(protectOn),
    .enableReg(enableReg), .selectReg(selectReg), .softReg(softReg),
    .inService(inService)
  );
endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                psel,
  input logic                penable,
  input logic                pwrite,
  input logic [11:0]         paddr,
  input logic [31:0]         pwdata,
  input logic                privAcc,
  input logic                irqReq,
  input logic                fiqReq,
  input logic                protectOn,
  input logic [NUM_SRC-1:0]  enableReg,
  input logic [NUM_SRC-1:0]  selectReg,
  input logic [NUM_SRC-1:0]  softReg,
  input logic [NUM_SLOT-1:0] inService
);
  logic wrAcc, wrAllowed, rdCur;
  assign wrAcc     = psel && penable && pwrite;
  assign wrAllowed = wrAcc && (!protectOn || privAcc);
  assign rdCur     = psel && penable && !pwrite && paddr == 12'h030;

  assert_enable_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrAllowed && paddr == 12'h010) |=>
      ((enableReg & $past(pwdata[NUM_SRC-1:0])) == $past(pwdata[NUM_SRC-1:0])));

  assert_enable_clr_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrAllowed && paddr == 12'h014) |=>
      ((enableReg & $past(pwdata[NUM_SRC-1:0])) == '0));

  assert_soft_raises_irq_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|(softReg & enableReg & ~selectReg)) |-> irqReq);

  assert_soft_raises_fiq_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|(softReg & enableReg & selectReg)) |-> fiqReq);

  assert_only_read_takes_R7: assert property (@(posedge clk) disable iff (!rstN)
    !rdCur |=> ((inService & ~$past(inService)) == '0));

  assert_one_take_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdCur |=> $onehot0(inService & ~$past(inService)));

  assert_ack_pops_one_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrAllowed && paddr == 12'h030) |=>
      ($past(inService) == '0 ||
       $countones(inService) + 1 == $countones($past(inService))));

  assert_protect_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && protectOn && !privAcc) |=>
      ($stable(enableReg) && $stable(selectReg) && $stable(softReg) && $stable(protectOn)));
endmodule

bind vec_intc vec_intc_chk #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT)) u_chk (
  .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .privAcc(privAcc), .irqReq(irqReq),
  .fiqReq(fiqReq), .protectOn(protectOn), .enableReg(enableReg),
  .selectReg(selectReg), .softReg(softReg), .inService(inService)
);

// File: tb/test_vec_intc.sv
module test_vec_intc;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ID = 32'h0015_5A3C;
  localparam logic [31:0] DEFV = 32'hDEAD_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0, privAcc = 1'b1;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [31:0] srcLines = '0;
  logic irqReq, fiqReq;
  int tests = 0, fails = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles++;

  vec_intc i_vec_intc (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .privAcc(privAcc), .prdata(prdata),
    .srcLines(srcLines), .irqReq(irqReq), .fiqReq(fiqReq)
  );

  function automatic int srcOf(int n); return (7 * n) % 32; endfunction
  function automatic logic [31:0] addrOf(int n); return 32'h4000_0000 + 32'(n * 16); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apbWrite(logic [11:0] a, logic [31:0] d, logic priv = 1'b1);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d; privAcc = priv;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0; privAcc = 1;
  endtask

  task automatic apbRead(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic expectRead(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    apbRead(a, d);
    check(req, d, exp);
  endtask

  initial begin
    wait (cycles > 100000);
    fails++;
    $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] lines;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10 reset state and unmapped offsets
    expectRead("R10 enable", 12'h010, 0);
    expectRead("R10 select", 12'h00C, 0);
    expectRead("R10 soft", 12'h018, 0);
    expectRead("R10 protect", 12'h020, 0);
    expectRead("R10 slot ctl", 12'h200, 0);
    check("R10 irqReq", 32'(irqReq), 0);
    apbWrite(12'h300, 32'h0000_0001);
    expectRead("R10 test word", 12'h300, 0);
    expectRead("R10 enable clear reads 0", 12'h014, 0);
    apbWrite(12'h011, 32'hFFFF_FFFF);
    expectRead("R10 unaligned write ignored", 12'h010, 0);

    // R9 ID bytes
    for (int k = 0; k < 4; k++)
      expectRead("R9 id byte", 12'hFE0 + 12'(4 * k), {24'd0, ID[8*k +: 8]});

    // R1 raw status per line
    for (int i = 0; i < 32; i++) begin
      srcLines = 32'd1 << i;
      expectRead("R1 raw line", 12'h008, 32'd1 << i);
    end
    srcLines = 0;

    // R2 enable set/clear
    apbWrite(12'h010, 32'hF0F0_00FF);
    expectRead("R2 set", 12'h010, 32'hF0F0_00FF);
    apbWrite(12'h014, 32'h1000_000F);
    expectRead("R2 clear", 12'h010, 32'hE0F0_00F0);
    apbWrite(12'h010, 32'h0);
    apbWrite(12'h014, 32'h0);
    expectRead("R2 zero writes keep", 12'h010, 32'hE0F0_00F0);

    // R3 soft pending
    apbWrite(12'h018, 32'h0000_0030);
    expectRead("R3 soft read", 12'h018, 32'h0000_0030);
    expectRead("R3 raw from soft", 12'h008, 32'h0000_0030);
    check("R3 irqReq from soft", 32'(irqReq), 1);
    apbWrite(12'h01C, 32'h0000_0010);
    expectRead("R3 soft clear", 12'h008, 32'h0000_0020);
    apbWrite(12'h01C, 32'hFFFF_FFFF);
    expectRead("R3 soft all clear", 12'h018, 0);

    // R4 routing sweep
    apbWrite(12'h010, 32'hFFFF_FFFF);
    apbWrite(12'h00C, 32'hAAAA_5555);
    for (int i = 0; i < 32; i++) begin
      srcLines = 32'd1 << i;
      expectRead("R4 irq status", 12'h000, (32'd1 << i) & ~32'hAAAA_5555);
      expectRead("R4 fiq status", 12'h004, (32'd1 << i) & 32'hAAAA_5555);
      check("R4 irqReq", 32'(irqReq), 32'(((32'd1 << i) & ~32'hAAAA_5555) != 0));
      check("R4 fiqReq", 32'(fiqReq), 32'(((32'd1 << i) & 32'hAAAA_5555) != 0));
    end
    srcLines = 0;
    apbWrite(12'h014, 32'h0000_FFFF);
    srcLines = 32'h0000_0100;
    expectRead("R4 masked source", 12'h000, 0);
    apbWrite(12'h010, 32'hFFFF_FFFF);
    apbWrite(12'h00C, 32'h0);
    srcLines = 0;

    // R5 slot registers
    for (int n = 0; n < 16; n++) begin
      apbWrite(12'h100 + 12'(4 * n), addrOf(n));
      apbWrite(12'h200 + 12'(4 * n), 32'hFFFF_FFE0 | 32'(srcOf(n)));
    end
    for (int n = 0; n < 16; n++) begin
      expectRead("R5 slot addr", 12'h100 + 12'(4 * n), addrOf(n));
      expectRead("R5 slot ctl", 12'h200 + 12'(4 * n), 32'h20 | 32'(srcOf(n)));
    end

    // R6 priority sweep
    apbWrite(12'h034, DEFV);
    expectRead("R6 default readback", 12'h034, DEFV);
    for (int i = 0; i < 16; i++) begin
      lines = 0;
      for (int j = i; j < 16; j++) lines |= 32'd1 << srcOf(j);
      srcLines = lines;
      expectRead("R6 winner", 12'h030, addrOf(i));
      apbWrite(12'h030, 32'h0);
    end
    srcLines = 32'd1 << 1;
    expectRead("R6 no slot gives default", 12'h030, DEFV);
    apbWrite(12'h200, 32'h0000_0000);
    srcLines = (32'd1 << srcOf(0)) | (32'd1 << srcOf(3));
    expectRead("R6 disabled slot skipped", 12'h030, addrOf(3));
    apbWrite(12'h030, 32'h0);
    apbWrite(12'h200, 32'h20 | 32'(srcOf(0)));

    // R7 nesting
    srcLines = 32'd1 << srcOf(5);
    expectRead("R7 take slot 5", 12'h030, addrOf(5));
    expectRead("R7 slot 5 blocks itself", 12'h030, DEFV);
    srcLines |= 32'd1 << srcOf(9);
    expectRead("R7 lower priority blocked", 12'h030, DEFV);
    srcLines |= 32'd1 << srcOf(2);
    expectRead("R7 higher preempts", 12'h030, addrOf(2));
    expectRead("R7 slot 2 blocked while served", 12'h030, DEFV);
    apbWrite(12'h030, 32'h1234);
    expectRead("R7 pop 2 then retake", 12'h030, addrOf(2));
    apbWrite(12'h030, 32'h0);
    apbWrite(12'h030, 32'h0);
    srcLines = (32'd1 << srcOf(5)) | (32'd1 << srcOf(9));
    expectRead("R7 fully unwound", 12'h030, addrOf(5));
    apbWrite(12'h030, 32'h0);
    apbWrite(12'h030, 32'h0);
    srcLines = 32'd1 << srcOf(9);
    expectRead("R7 empty pop harmless", 12'h030, addrOf(9));
    apbWrite(12'h030, 32'h0);
    srcLines = 0;

    // R8 protection
    apbWrite(12'h014, 32'hFFFF_FFFF);
    apbWrite(12'h020, 32'h1);
    expectRead("R8 protect set", 12'h020, 1);
    apbWrite(12'h010, 32'h0000_FFFF, 1'b0);
    expectRead("R8 user write blocked", 12'h010, 0);
    apbWrite(12'h018, 32'h0000_0001, 1'b0);
    expectRead("R8 user soft blocked", 12'h018, 0);
    apbWrite(12'h010, 32'h0000_00F0, 1'b1);
    expectRead("R8 privileged write", 12'h010, 32'h0000_00F0);
    apbWrite(12'h020, 32'h0);
    apbWrite(12'h010, 32'h0000_0F00, 1'b0);
    expectRead("R8 user write after unprotect", 12'h010, 32'h0000_0FF0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule